// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Unit

This unit turns one 4x4 tile of signed 16-bit transform coefficients back into pixels. It runs a four-point integer inverse cosine transform along each row, then along each column of the row results, scales the residual down with rounding, adds it to an 8-bit prediction tile, and clamps every sum into the pixel range. The butterfly constants are 14-bit fixed-point values and every rounding point is fixed, so the output matches a software decoder bit for bit.

A caller presents all sixteen coefficients, all sixteen prediction pixels and the position of the last non-zero coefficient in scan order, then pulses `start`. That position picks how much of the tile is read. With only the DC term, the top-left 2x2 corner, or the whole tile, every coefficient outside the chosen region is treated as zero. All sixteen reconstructed pixels appear together for one cycle, and a done pulse follows them. The internal coefficient copy is wiped once it has been consumed.

Top module: `idct4_recon`

## Requirements
- R1: The even half of each 4-point pass forms a = x0+x2 and b = x0−x2, each wrapped to 16 bits. It then produces s0 = (a·11585 + 8192) >>> 14 and s1 = (b·11585 + 8192) >>> 14.
- R2: The odd half produces s2 = (x1·6270 − x3·15137 + 8192) >>> 14 and s3 = (x1·15137 + x3·6270 + 8192) >>> 14. Each value saturates to the signed 16-bit range.
- R3: The pass outputs are y0 = s0+s3, y1 = s1+s2, y2 = s1−s2 and y3 = s0−s3, each wrapped to 16 bits. The pass is applied first to every row of the tile and then to every column of the row results. Element k of a tile (coefficient, prediction or pixel) sits at row k/4, column k%4, in bits [16k+15:16k] of `coef_in` and [8k+7:8k] of `pred_in` and `pix_out`.
- R4: Each final residual r becomes (r+8) >>> 4 and is added to the unsigned prediction. The sum is clamped to 0..255.
- R5: When `last_pos` is 1, only coefficient 0 (the DC term) is used, and every other coefficient is treated as zero.
- R6: When `last_pos` is 0, 2, 3 or 4, only coefficients 0, 1, 4 and 5 (the top-left 2x2 corner) are used, and the rest are treated as zero.
- R7: When `last_pos` is 5 or more, all sixteen coefficients are used.
- R8: The stored coefficient copy is all zero from the cycle after the row pass until the next accepted start.
- R9: A start accepted at clock edge E gives `pix_valid` high for exactly the cycle after edge E+2. `done` is high for exactly the cycle after that. `busy` is high from edge E+1 through the `pix_valid` cycle.
- R10: A `start` seen while `busy` is high is ignored, and the inputs of that cycle do not affect any result. A `start` during the `done` cycle is accepted.
- R11: After reset, `busy`, `pix_valid` and `done` are low and `pix_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to process the tile on the data inputs |
| last_pos | input | 5 | Scan position of the last non-zero coefficient, plus one; selects the region read |
| coef_in | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| pred_in | input | 128 | Sixteen unsigned 8-bit prediction pixels, raster order |
| busy | output | 1 | Tile in flight; a new start is refused |
| pix_valid | output | 1 | One-cycle strobe marking `pix_out` as the new tile |
| pix_out | output | 128 | Sixteen reconstructed 8-bit pixels, raster order |
| done | output | 1 | One-cycle pulse in the cycle after `pix_valid` |

## Verification
The embedded properties watch the handshake timing on every cycle. They check the single-cycle valid strobe, the done pulse that follows it, and the prediction copy held steady while busy. They also check that the coefficient copy is empty during the column pass and that the DC and corner selections leave nothing outside their region. The arithmetic can only be shown by the bench's scenarios, which compare every pixel against an integer model. Those scenarios cover saturating odd-part inputs, transposition-sensitive single coefficients, clamping at both ends of the pixel range, garbage outside the selected region, and starts held high across busy and done cycles.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

   // fixed-point format of the butterfly multipliers
   localparam int FRAC   = 14;
   localparam int HALF   = 1 << (FRAC - 1);
   localparam int C_PI4  = 11585;
   localparam int C_LO   = 6270;
   localparam int C_HI   = 15137;

   // final residual scaling
   localparam int OUT_SHIFT = 4;
   localparam int OUT_BIAS  = 1 << (OUT_SHIFT - 1);

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_OUT
   } phase_t;

   typedef enum logic [1:0] {
      SEL_DC,
      SEL_CORNER,
      SEL_FULL
   } region_t;

endpackage

// File: rtl/idct4_bfly.sv
module idct4_bfly
   import idct4_pkg::*;
#(
   parameter int W = 16
) (
   input  logic signed [W-1:0] x0,
   input  logic signed [W-1:0] x1,
   input  logic signed [W-1:0] x2,
   input  logic signed [W-1:0] x3,
   output logic signed [W-1:0] y0,
   output logic signed [W-1:0] y1,
   output logic signed [W-1:0] y2,
   output logic signed [W-1:0] y3
);

   // wide enough for a W-bit operand times a 15-bit constant, plus a sum
   localparam int PW = W + 17;
   localparam logic signed [PW-1:0] TOP = PW'((1 << (W - 1)) - 1);
   localparam logic signed [PW-1:0] BOT = -TOP - PW'(1);

   function automatic logic signed [W-1:0] round_sat(input logic signed [PW-1:0] acc);
      logic signed [PW-1:0] sh;
      sh = (acc + PW'(HALF)) >>> FRAC;
      if (sh > TOP)      return TOP[W-1:0];
      else if (sh < BOT) return BOT[W-1:0];
      else               return sh[W-1:0];
   endfunction

   logic signed [W-1:0] even_sum, even_dif;
   logic signed [W-1:0] s0, s1, s2, s3;

   always_comb begin
      // even half: sums wrap at W bits
      even_sum = x0 + x2;
      even_dif = x0 - x2;
      s0 = round_sat(PW'(even_sum) * PW'(C_PI4));
      s1 = round_sat(PW'(even_dif) * PW'(C_PI4));
      // odd half: rotate x1/x3
      s2 = round_sat(PW'(x1) * PW'(C_LO) - PW'(x3) * PW'(C_HI));
      s3 = round_sat(PW'(x1) * PW'(C_HI) + PW'(x3) * PW'(C_LO));
      // recombine, wrapping at W bits
      y0 = s0 + s3;
      y1 = s1 + s2;
      y2 = s1 - s2;
      y3 = s0 - s3;
   end

endmodule

// File: rtl/idct4_lane.sv
module idct4_lane
   import idct4_pkg::*;
#(
   parameter int W = 16,
   parameter int P = 8
) (
   input  logic signed [W-1:0] res,
   input  logic        [P-1:0] pred,
   output logic        [P-1:0] pix
);

   localparam int PMAX = (1 << P) - 1;

   logic signed [W:0]   biased;
   logic signed [W:0]   scaled;
   logic signed [W+1:0] total;

   always_comb begin
      biased = (W+1)'(res) + (W+1)'(OUT_BIAS);
      scaled = biased >>> OUT_SHIFT;
      total  = (W+2)'(scaled) + (W+2)'($signed({1'b0, pred}));
      if (total < 0)
         pix = '0;
      else if (total > (W+2)'(PMAX))
         pix = '1;
      else
         pix = total[P-1:0];
   end

endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
   import idct4_pkg::*;
#(
   parameter int COEF_W      = 16,
   parameter int PIX_W       = 8,
   parameter int POS_W       = 5,
   parameter int DC_POS      = 1,
   parameter int CORNER_POS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [POS_W-1:0]        last_pos,
   input  logic [16*COEF_W-1:0]    coef_in,
   input  logic [16*PIX_W-1:0]     pred_in,
   output logic                    busy,
   output logic                    pix_valid,
   output logic [16*PIX_W-1:0]     pix_out,
   output logic                    done
);

   localparam int N      = 4;
   localparam int NC     = N * N;
   localparam int CORNER = N / 2;

   // elaboration-time parameter checks
   if (COEF_W < 8 || COEF_W > 24) begin : g_chk_w
      $error("idct4_recon: COEF_W out of supported range");
   end
   if (PIX_W < 1 || PIX_W >= COEF_W) begin : g_chk_p
      $error("idct4_recon: PIX_W must be below COEF_W");
   end
   if ((1 << POS_W) <= NC) begin : g_chk_pos
      $error("idct4_recon: POS_W too narrow for a full tile count");
   end
   if (CORNER_POS <= DC_POS) begin : g_chk_thr
      $error("idct4_recon: corner threshold must exceed the DC threshold");
   end

   phase_t                      st;
   region_t                     region_d, region_q;
   logic [NC-1:0][COEF_W-1:0]   store;
   logic [NC-1:0][COEF_W-1:0]   mid;
   logic [NC-1:0][PIX_W-1:0]    pred_q;
   logic [NC-1:0][PIX_W-1:0]    pix_q;
   logic [NC-1:0]               keep;
   logic signed [COEF_W-1:0]    res   [NC];
   logic        [PIX_W-1:0]     pix_c [NC];

   // region chosen from the last-position count
   always_comb begin
      if (last_pos == POS_W'(DC_POS))
         region_d = SEL_DC;
      else if (last_pos <= POS_W'(CORNER_POS))
         region_d = SEL_CORNER;
      else
         region_d = SEL_FULL;
   end

   for (genvar k = 0; k < NC; k++) begin : g_keep
      localparam bit IN_CORNER = ((k / N) < CORNER) && ((k % N) < CORNER);
      localparam bit IS_DC     = (k == 0);
      assign keep[k] = (region_d == SEL_FULL)
                    || ((region_d == SEL_CORNER) && IN_CORNER)
                    || IS_DC;
   end

   // one set of four butterflies, shared by the row and the column pass
   for (genvar g = 0; g < N; g++) begin : g_bfly
      logic signed [COEF_W-1:0] xi [N];
      logic signed [COEF_W-1:0] yo [N];
      for (genvar i = 0; i < N; i++) begin : g_sel
         assign xi[i]       = (st == ST_ROW) ? $signed(store[g*N+i]) : $signed(mid[i*N+g]);
         assign res[i*N+g]  = yo[i];
      end
      idct4_bfly #(.W(COEF_W)) u_bf (
         .x0(xi[0]), .x1(xi[1]), .x2(xi[2]), .x3(xi[3]),
         .y0(yo[0]), .y1(yo[1]), .y2(yo[2]), .y3(yo[3])
      );
   end

   // per-pixel scaling, add and clamp
   for (genvar k = 0; k < NC; k++) begin : g_lane
      idct4_lane #(.W(COEF_W), .P(PIX_W)) u_ln (
         .res (res[k]),
         .pred(pred_q[k]),
         .pix (pix_c[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         region_q  <= SEL_FULL;
         store     <= '0;
         mid       <= '0;
         pred_q    <= '0;
         pix_q     <= '0;
         pix_valid <= 1'b0;
         done      <= 1'b0;
      end else begin
         pix_valid <= 1'b0;
         done      <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  for (int k = 0; k < NC; k++)
                     store[k] <= keep[k] ? coef_in[k*COEF_W +: COEF_W] : '0;
                  pred_q   <= pred_in;
                  region_q <= region_d;
                  st       <= ST_ROW;
               end
            end
            ST_ROW: begin
               // row g result y_i lands in res[i*N+g]; keep it row-major
               for (int r = 0; r < N; r++)
                  for (int c = 0; c < N; c++)
                     mid[r*N+c] <= res[c*N+r];
               store <= '0;
               st    <= ST_COL;
            end
            ST_COL: begin
               for (int k = 0; k < NC; k++)
                  pix_q[k] <= pix_c[k];
               pix_valid <= 1'b1;
               st        <= ST_OUT;
            end
            ST_OUT: begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign pix_out = pix_q;

   // embedded checks
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (!pix_valid && done));                              // R9
   AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(pix_valid));                                       // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pix_valid);                                            // R9
   AST_STORE_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COL) |-> (store == '0));                                // R8
   AST_BUSY_HOLDS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(pred_q));                             // R10
   AST_DC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ROW) && (region_q == SEL_DC)) |-> (store[NC-1:1] == '0)); // R5
   AST_CORNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ROW) && (region_q == SEL_CORNER))
         |-> ((store[3:2] == '0) && (store[NC-1:6] == '0)));            // R6

endmodule

// File: tb/sim_idct4_recon.sv
`timescale 1ns/1ps
module sim_idct4_recon;

   localparam int W  = 16;
   localparam int P  = 8;
   localparam int NC = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [4:0]        cnt = '0;
   logic [NC*W-1:0]   coef = '0;
   logic [NC*P-1:0]   pred = '0;
   wire               busy, pix_valid, done;
   wire  [NC*P-1:0]   pix_out;

   always #2.5 clk = ~clk;

   idct4_recon u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .last_pos(cnt),
      .coef_in(coef), .pred_in(pred),
      .busy(busy), .pix_valid(pix_valid), .pix_out(pix_out), .done(done)
   );

   int n_chk = 0;
   int n_fail = 0;
   int m = 0;
   logic [NC*P-1:0] expq[$];
   string cur_req = "R7";

   // ---------------- reference model ----------------
   function automatic int wrap16(int v);
      int t;
      t = v & 32'h0000FFFF;
      if (t >= 32768) t = t - 65536;
      return t;
   endfunction

   function automatic int rnd14(longint a);
      longint s;
      s = (a + 8192) >>> 14;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   function automatic void pass4(input int x[4], output int y[4]);
      int s0, s1, s2, s3;
      s0 = rnd14(longint'(wrap16(x[0] + x[2])) * 11585);
      s1 = rnd14(longint'(wrap16(x[0] - x[2])) * 11585);
      s2 = rnd14(longint'(x[1]) * 6270 - longint'(x[3]) * 15137);
      s3 = rnd14(longint'(x[1]) * 15137 + longint'(x[3]) * 6270);
      y[0] = wrap16(s0 + s3);
      y[1] = wrap16(s1 + s2);
      y[2] = wrap16(s1 - s2);
      y[3] = wrap16(s0 - s3);
   endfunction

   function automatic logic [NC*P-1:0] model(logic [NC*W-1:0] c, logic [NC*P-1:0] p, int n);
      int a[16];
      int t[16];
      int x[4];
      int y[4];
      logic [NC*P-1:0] o;
      for (int k = 0; k < 16; k++) begin
         bit use_it;
         if (n == 1)      use_it = (k == 0);
         else if (n <= 4) use_it = ((k / 4) < 2) && ((k % 4) < 2);
         else             use_it = 1'b1;
         a[k] = use_it ? int'($signed(c[k*W +: W])) : 0;
      end
      for (int r = 0; r < 4; r++) begin
         for (int j = 0; j < 4; j++) x[j] = a[r*4+j];
         pass4(x, y);
         for (int j = 0; j < 4; j++) t[r*4+j] = y[j];
      end
      for (int col = 0; col < 4; col++) begin
         for (int i = 0; i < 4; i++) x[i] = t[i*4+col];
         pass4(x, y);
         for (int i = 0; i < 4; i++) begin
            int v;
            v = ((y[i] + 8) >>> 4) + int'(p[(i*4+col)*P +: P]);
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            o[(i*4+col)*P +: P] = P'(v);
         end
      end
      return o;
   endfunction

   // ---------------- cycle model ----------------
   always @(posedge clk) begin
      if (!rst_n) m = 0;
      else if (m == 0 || m == 4) begin
         if (start) begin
            m = 1;
            expq.push_back(model(coef, pred, int'(cnt)));
         end else m = 0;
      end else m = m + 1;
   end

   task automatic chk(bit ok, string req, logic [NC*P-1:0] act, logic [NC*P-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] ea, aa;
         ea = {(m >= 1 && m <= 3), (m == 3), (m == 4)};
         aa = {busy, pix_valid, done};
         chk(aa === ea, "R9", 128'(aa), 128'(ea));
         if (m == 3) begin
            logic [NC*P-1:0] e;
            e = expq.pop_front();
            chk(pix_out === e, cur_req, pix_out, e);
         end
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [NC*W-1:0] rand_coef(int range);
      logic [NC*W-1:0] v;
      for (int k = 0; k < NC; k++)
         v[k*W +: W] = W'(int'($urandom_range(0, 2*range)) - range);
      return v;
   endfunction

   function automatic logic [NC*P-1:0] rand_pred();
      logic [NC*P-1:0] v;
      for (int k = 0; k < NC; k++) v[k*P +: P] = P'($urandom_range(0, 255));
      return v;
   endfunction

   function automatic logic [NC*W-1:0] one_coef(int k, int val);
      logic [NC*W-1:0] v;
      v = '0;
      v[k*W +: W] = W'(val);
      return v;
   endfunction

   task automatic send(int n, logic [NC*W-1:0] c, logic [NC*P-1:0] p, string req);
      @(negedge clk);
      cur_req = req;
      coef = c; pred = p; cnt = 5'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      coef = rand_coef(32767);
      pred = rand_pred();
      repeat (5) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [NC*W-1:0] sat;
      logic [NC*P-1:0] flat;
      repeat (3) @(negedge clk);
      chk({busy, pix_valid, done} === 3'b000 && pix_out === '0, "R11",
          {125'd0, busy, pix_valid, done} | 128'(pix_out), '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3: small mixed values, full tile
      send(16, rand_coef(200), rand_pred(), "R1");
      send(16, rand_coef(2000), rand_pred(), "R3");
      // R7: full-range values
      for (int i = 0; i < 6; i++) send(16, rand_coef(32767), rand_pred(), "R7");
      // R2: odd part saturates
      sat = '0;
      for (int r = 0; r < 4; r++) begin
         sat[(r*4+1)*W +: W] = 16'sd32767;
         sat[(r*4+3)*W +: W] = 16'sd32767;
      end
      send(16, sat, {NC{8'd128}}, "R2");
      for (int r = 0; r < 4; r++) begin
         sat[(r*4+1)*W +: W] = -16'sd32768;
         sat[(r*4+3)*W +: W] = 16'sd32767;
      end
      send(16, sat, {NC{8'd128}}, "R2");
      // R3: transposition shows in single off-axis coefficients
      send(16, one_coef(1, 640), {NC{8'd100}}, "R3");
      send(16, one_coef(4, 640), {NC{8'd100}}, "R3");
      send(16, one_coef(7, -900), {NC{8'd100}}, "R3");
      // R4: clamp high and low
      send(16, one_coef(0, 4000), {NC{8'd250}}, "R4");
      send(16, one_coef(0, -4000), {NC{8'd3}}, "R4");
      flat = rand_pred();
      send(16, rand_coef(30000), flat, "R4");
      // R5: DC only, garbage elsewhere
      send(1, rand_coef(32767), rand_pred(), "R5");
      send(1, rand_coef(5000), rand_pred(), "R5");
      // R6: corner only for counts 0, 2, 3, 4
      send(0, rand_coef(32767), rand_pred(), "R6");
      send(2, rand_coef(32767), rand_pred(), "R6");
      send(3, rand_coef(3000), rand_pred(), "R6");
      send(4, rand_coef(32767), rand_pred(), "R6");
      // R7: count just above the corner threshold
      send(5, rand_coef(32767), rand_pred(), "R7");
      // R10: start held high with data changing every cycle
      @(negedge clk);
      cur_req = "R10";
      cnt = 5'd16;
      start = 1'b1;
      for (int i = 0; i < 14; i++) begin
         coef = rand_coef(32767);
         pred = rand_pred();
         @(negedge clk);
      end
      start = 1'b0;
      repeat (8) @(negedge clk);
      summary();
      $finish;
   end

endmodule